// File: doc/BRIEF.md
# Secure-filtered interrupt bitmap bank

This block stores one enable bit, one pending bit and one active bit for each shared interrupt. It also stores a trigger-mode bit, a group bit and a 2-bit access grant for each interrupt. The bits are packed 32 interrupts to a word. Software changes a bitmap through a pair of windows. A 1 written to the set window sets the matching bits. A 1 written to the clear window clears them. Either window reads back the current bitmap.

Every request carries a secure attribute. While the security-off control bit is 0, a non-secure request can reach only some bit lanes of a word. A lane is reachable when the interrupt's group bit is 1. It is also reachable when the interrupt's access grant meets the level that the window requires. All other lanes read as zero, and writes to them leave the stored bits unchanged.

External interrupt lines feed the pending state. A rising edge on an edge-triggered line latches its pending bit. A read of pending for a level-triggered interrupt also shows the live line level.

Top module: `irq_bitmap_bank`

## Requirements
- R1: Address bits [8:5] select the window and bits [4:0] select the word. Bitmap word w covers interrupt IDs 32w to 32w+31, with ID 32w+b at bit b. Word 0 (IDs below 32) and words at or above NUM_IRQ/32 read as zero and ignore writes. Grant words outside 2 to 2*NUM_IRQ/32-1 do the same.
- R2: Window 4 sets enable bits and window 5 clears them. Window 6 sets pending bits and window 7 clears them. Window 8 sets active bits and window 9 clears them. A written 1 sets or clears its bit, and a written 0 has no effect. Both windows of a pair read the same bitmap.
- R3: A secure request reaches every lane, and so does any request once the security-off bit is 1.
- R4: For a non-secure request while the security-off bit is 0, the enable windows and the trigger window reach only the lanes whose group bit is 1.
- R5: Grant word k (window 3) holds IDs 16k to 16k+15, with ID 16k+j in bits [2j+1:2j]. The grant codes are: 00 none; 01 set pending; 10 also clear pending and read active; 11 also routing. Under masking, the set-pending window opens a lane whose grant is 01 or higher. The clear-pending window opens a lane whose grant is 10 or higher. A lane whose group bit is 1 is always open.
- R6: Under masking, active writes reach only lanes whose group bit is 1. Active reads also reach lanes whose grant is 10 or higher.
- R7: A pending read returns the stored pending bit ORed with the live line level. The line level is added only where the trigger bit (window 2) is 0, meaning level-triggered.
- R8: A 0-to-1 change on a line whose trigger bit is 1 sets the pending bit on the first clock edge that sees the high level. A line that stays high or falls does not set the bit. A level-triggered line never latches.
- R9: When a rising edge and a clear-pending write hit the same bit in the same cycle, the bit ends set.
- R10: The group window (1) and the grant window (3) read as zero and ignore writes for non-secure requests while the security-off bit is 0. The grant window also reads as zero and ignores writes once the security-off bit is 1.
- R11: Bit 0 of window 0, word 0, is the security-off bit, and it resets to 0. Only a secure write can set it, and only while it is 0. Once set, it stays set until reset.
- R12: A read returns rsp_rdata_o with rsp_valid_o high in the cycle after the request. All state resets to zero.
- R13: The trigger window stores one bit per interrupt, where 1 means edge-triggered. Its write and read are filtered by the group-bit lane mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Secure attribute of the request |
| req_addr_i | input | 9 | {window[3:0], word[4:0]} |
| req_wdata_i | input | 32 | Write data |
| irq_lines_i | input | NUM_IRQ-32 | Line j drives interrupt ID 32+j |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The hardest case to reach is a clear-pending write that lands in the same cycle as a rising edge on the same line. The bench changes the line and presents the clear request at the same falling clock edge, so both reach the same rising edge. The grant-dependent lanes take setup first. Secure writes program the group bits and three distinct grant codes in one word. Non-secure set, clear and read requests then show each threshold lane by lane.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int WIN_W  = 4;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = WIN_W + IDX_W;

  typedef enum logic [WIN_W-1:0] {
    WIN_CTRL     = 4'd0,
    WIN_GROUP    = 4'd1,
    WIN_TRIG     = 4'd2,
    WIN_GRANT    = 4'd3,
    WIN_EN_SET   = 4'd4,
    WIN_EN_CLR   = 4'd5,
    WIN_PEND_SET = 4'd6,
    WIN_PEND_CLR = 4'd7,
    WIN_ACT_SET  = 4'd8,
    WIN_ACT_CLR  = 4'd9
  } win_e;

  typedef enum logic [1:0] {
    THR_GROUP = 2'd0,
    THR_GE1   = 2'd1,
    THR_GE2   = 2'd2
  } thr_e;
endpackage

// File: rtl/irq_lane_mask.sv
module irq_lane_mask
  import irq_bank_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic                 restrict_i,
  input  logic [LANES-1:0]     group_i,
  input  logic [2*LANES-1:0]   grant_i,
  input  thr_e                 thr_i,
  output logic [LANES-1:0]     mask_o
);
  logic [LANES-1:0] ge1, ge2, allow;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign ge1[l] = |grant_i[2*l +: 2];
    assign ge2[l] = grant_i[2*l+1];
  end

  always_comb begin
    unique case (thr_i)
      THR_GE1: allow = group_i | ge1;
      THR_GE2: allow = group_i | ge2;
      default: allow = group_i;
    endcase
    mask_o = restrict_i ? allow : '1;
  end
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] line_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= line_i;
  end

  assign rise_o = line_i & ~prev_q;
endmodule

// File: rtl/irq_bit_word.sv
module irq_bit_word #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_bitmap_bank.sv
module irq_bitmap_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_IRQ = 96
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic                  req_write_i,
  input  logic                  req_secure_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [31:0]           req_wdata_i,
  input  logic [NUM_IRQ-33:0]   irq_lines_i,
  output logic                  rsp_valid_o,
  output logic [31:0]           rsp_rdata_o
);
  localparam int NW = NUM_IRQ / 32;
  localparam int NG = 2 * NW;

  win_e             win;
  logic [IDX_W-1:0] idx;
  logic             wr, rd, restrict_acc, sec_full;
  logic             sec_off_q;
  thr_e             thr;
  logic [31:0]      rd_mux;

  logic [31:0] grp_q  [1:NW-1];
  logic [31:0] trig_q [1:NW-1];
  logic [31:0] en_q   [1:NW-1];
  logic [31:0] pend_q [1:NW-1];
  logic [31:0] act_q  [1:NW-1];
  logic [31:0] rd_word[1:NW-1];
  logic [31:0] grant_q[2:NG-1];

  assign win          = win_e'(req_addr_i[ADDR_W-1 -: WIN_W]);
  assign idx          = req_addr_i[IDX_W-1:0];
  assign wr           = req_valid_i & req_write_i;
  assign rd           = req_valid_i & ~req_write_i;
  assign restrict_acc = ~req_secure_i & ~sec_off_q;
  assign sec_full     = req_secure_i & ~sec_off_q;

  always_comb begin
    unique case (win)
      WIN_PEND_SET:             thr = THR_GE1;
      WIN_PEND_CLR:             thr = THR_GE2;
      WIN_ACT_SET, WIN_ACT_CLR: thr = req_write_i ? THR_GROUP : THR_GE2;
      default:                  thr = THR_GROUP;
    endcase
  end

  // security-off: one-way until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_off_q <= 1'b0;
    else if (wr && win == WIN_CTRL && idx == '0 && sec_full && req_wdata_i[0])
      sec_off_q <= 1'b1;
  end

  for (genvar k = 2; k < NG; k++) begin : g_grant
    logic wr_g;
    assign wr_g = wr && win == WIN_GRANT && idx == IDX_W'(k) && sec_full;
    irq_bit_word #(.W(32)) u_grant (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .set_i(wr_g ? req_wdata_i : 32'h0),
      .clr_i(wr_g ? ~req_wdata_i : 32'h0),
      .q_o  (grant_q[k])
    );
  end

  for (genvar w = 1; w < NW; w++) begin : g_word
    logic        hit, wr_w;
    logic [31:0] m, rise, level_view;
    logic [31:0] en_set, en_clr, pd_set, pd_clr, ac_set, ac_clr;
    logic [31:0] tr_set, tr_clr, gr_set, gr_clr;

    assign hit  = idx == IDX_W'(w);
    assign wr_w = wr & hit;

    irq_lane_mask #(.LANES(32)) u_mask (
      .restrict_i(restrict_acc),
      .group_i   (grp_q[w]),
      .grant_i   ({grant_q[2*w+1], grant_q[2*w]}),
      .thr_i     (thr),
      .mask_o    (m)
    );

    irq_edge_latch #(.W(32)) u_edge (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .line_i(irq_lines_i[32*(w-1) +: 32]),
      .rise_o(rise)
    );

    assign en_set = (wr_w && win == WIN_EN_SET)   ? req_wdata_i & m : '0;
    assign en_clr = (wr_w && win == WIN_EN_CLR)   ? req_wdata_i & m : '0;
    assign pd_set = ((wr_w && win == WIN_PEND_SET) ? req_wdata_i & m : '0)
                  | (rise & trig_q[w]);
    assign pd_clr = (wr_w && win == WIN_PEND_CLR) ? req_wdata_i & m : '0;
    assign ac_set = (wr_w && win == WIN_ACT_SET)  ? req_wdata_i & m : '0;
    assign ac_clr = (wr_w && win == WIN_ACT_CLR)  ? req_wdata_i & m : '0;
    assign tr_set = (wr_w && win == WIN_TRIG)     ? req_wdata_i & m : '0;
    assign tr_clr = (wr_w && win == WIN_TRIG)     ? ~req_wdata_i & m : '0;
    assign gr_set = (wr_w && win == WIN_GROUP && !restrict_acc) ? req_wdata_i  : '0;
    assign gr_clr = (wr_w && win == WIN_GROUP && !restrict_acc) ? ~req_wdata_i : '0;

    irq_bit_word #(.W(32)) u_en   (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(en_set), .clr_i(en_clr), .q_o(en_q[w]));
    irq_bit_word #(.W(32)) u_pend (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(pd_set), .clr_i(pd_clr), .q_o(pend_q[w]));
    irq_bit_word #(.W(32)) u_act  (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(ac_set), .clr_i(ac_clr), .q_o(act_q[w]));
    irq_bit_word #(.W(32)) u_trig (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(tr_set), .clr_i(tr_clr), .q_o(trig_q[w]));
    irq_bit_word #(.W(32)) u_grp  (.clk_i(clk_i), .rst_ni(rst_ni), .set_i(gr_set), .clr_i(gr_clr), .q_o(grp_q[w]));

    // level-triggered lines show through on pending reads
    assign level_view = irq_lines_i[32*(w-1) +: 32] & ~trig_q[w];

    always_comb begin
      unique case (win)
        WIN_GROUP:                  rd_word[w] = restrict_acc ? '0 : grp_q[w];
        WIN_TRIG:                   rd_word[w] = trig_q[w] & m;
        WIN_EN_SET, WIN_EN_CLR:     rd_word[w] = en_q[w] & m;
        WIN_PEND_SET, WIN_PEND_CLR: rd_word[w] = (pend_q[w] | level_view) & m;
        WIN_ACT_SET, WIN_ACT_CLR:   rd_word[w] = act_q[w] & m;
        default:                    rd_word[w] = '0;
      endcase
    end

    // R4
    en_ns_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_w && restrict_acc && (win == WIN_EN_SET || win == WIN_EN_CLR))
      |=> (((en_q[w] ^ $past(en_q[w])) & ~$past(grp_q[w])) == 32'h0));

    // R8
    edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(rise & trig_q[w]))
      |=> ((pend_q[w] & $past(rise & trig_q[w])) == $past(rise & trig_q[w])));
  end

  always_comb begin
    rd_mux = '0;
    unique case (win)
      WIN_CTRL:  if (idx == '0) rd_mux = {31'h0, sec_off_q};
      WIN_GRANT: for (int k = 2; k < NG; k++)
                   if (idx == IDX_W'(k) && sec_full) rd_mux = grant_q[k];
      default:   for (int w = 1; w < NW; w++)
                   if (idx == IDX_W'(w)) rd_mux = rd_word[w];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd;
      if (rd) rsp_rdata_o <= rd_mux;
    end
  end

  // R11
  sec_off_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_off_q |=> sec_off_q);

  // R12
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rsp_valid_o);

  // R12
  rsp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rsp_valid_o);

  // R10
  grp_ns_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && restrict_acc && win == WIN_GROUP) |=> (rsp_rdata_o == 32'h0));

  // R1
  low_word_raz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && idx == '0 && win != WIN_CTRL) |=> (rsp_rdata_o == 32'h0));
endmodule

// File: tb/irq_bitmap_bank_bench.sv
`timescale 1ns/1ps
module irq_bitmap_bank_bench;
  localparam int NUM_IRQ = 96;

  localparam logic [3:0] W_CTRL = 4'd0, W_GRP = 4'd1, W_TRIG = 4'd2, W_GRANT = 4'd3,
                         W_ENS = 4'd4, W_ENC = 4'd5, W_PDS = 4'd6, W_PDC = 4'd7,
                         W_ACS = 4'd8, W_ACC = 4'd9;

  typedef struct packed {
    logic        sec;
    logic        wr;
    logic [3:0]  win;
    logic [4:0]  idx;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,W_ENS,  5'd1, 32'h0,        32'h0,        8'd12}, // R12 reset
    '{1'b1,1'b1,W_ENS,  5'd1, 32'h000000FF, 32'h0,        8'd2},
    '{1'b1,1'b0,W_ENC,  5'd1, 32'h0,        32'h000000FF, 8'd2},  // R2
    '{1'b1,1'b1,W_ENC,  5'd1, 32'h0000000F, 32'h0,        8'd2},
    '{1'b1,1'b0,W_ENS,  5'd1, 32'h0,        32'h000000F0, 8'd2},  // R2
    '{1'b1,1'b1,W_ENS,  5'd1, 32'h0,        32'h0,        8'd2},
    '{1'b1,1'b0,W_ENS,  5'd1, 32'h0,        32'h000000F0, 8'd2},  // R2 zero no-op
    '{1'b1,1'b1,W_ENS,  5'd0, 32'hFFFFFFFF, 32'h0,        8'd1},
    '{1'b1,1'b0,W_ENS,  5'd0, 32'h0,        32'h0,        8'd1},  // R1
    '{1'b1,1'b1,W_ENS,  5'd3, 32'hFFFFFFFF, 32'h0,        8'd1},
    '{1'b1,1'b0,W_ENS,  5'd3, 32'h0,        32'h0,        8'd1},  // R1
    '{1'b1,1'b1,W_ENS,  5'd2, 32'hFFFF0000, 32'h0,        8'd2},
    '{1'b1,1'b0,W_ENS,  5'd2, 32'h0,        32'hFFFF0000, 8'd2},  // R2
    '{1'b1,1'b1,W_GRP,  5'd1, 32'h0000FFFF, 32'h0,        8'd10},
    '{1'b1,1'b0,W_GRP,  5'd1, 32'h0,        32'h0000FFFF, 8'd10}, // R10
    '{1'b0,1'b0,W_GRP,  5'd1, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b0,1'b1,W_GRP,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd10},
    '{1'b1,1'b0,W_GRP,  5'd1, 32'h0,        32'h0000FFFF, 8'd10}, // R10
    '{1'b0,1'b1,W_ENS,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b1,1'b0,W_ENS,  5'd1, 32'h0,        32'h0000FFFF, 8'd4},  // R4
    '{1'b1,1'b1,W_ENS,  5'd1, 32'hFFFF0000, 32'h0,        8'd3},
    '{1'b0,1'b0,W_ENS,  5'd1, 32'h0,        32'h0000FFFF, 8'd4},  // R4
    '{1'b0,1'b1,W_ENC,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd4},
    '{1'b1,1'b0,W_ENC,  5'd1, 32'h0,        32'hFFFF0000, 8'd4},  // R4
    '{1'b1,1'b1,W_GRANT,5'd3, 32'h00000039, 32'h0,        8'd5},
    '{1'b1,1'b0,W_GRANT,5'd3, 32'h0,        32'h00000039, 8'd10}, // R10
    '{1'b0,1'b0,W_GRANT,5'd3, 32'h0,        32'h0,        8'd10}, // R10
    '{1'b1,1'b1,W_GRANT,5'd1, 32'hFFFFFFFF, 32'h0,        8'd1},
    '{1'b1,1'b0,W_GRANT,5'd1, 32'h0,        32'h0,        8'd1},  // R1
    '{1'b0,1'b1,W_PDS,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b1,1'b0,W_PDS,  5'd1, 32'h0,        32'h0007FFFF, 8'd5},  // R5
    '{1'b0,1'b0,W_PDC,  5'd1, 32'h0,        32'h0006FFFF, 8'd5},  // R5
    '{1'b0,1'b1,W_PDC,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd5},
    '{1'b1,1'b0,W_PDS,  5'd1, 32'h0,        32'h00010000, 8'd5},  // R5
    '{1'b0,1'b1,W_ACS,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b1,1'b1,W_ACS,  5'd1, 32'h00070000, 32'h0,        8'd6},
    '{1'b0,1'b0,W_ACS,  5'd1, 32'h0,        32'h0006FFFF, 8'd6},  // R6
    '{1'b0,1'b1,W_ACC,  5'd1, 32'hFFFFFFFF, 32'h0,        8'd6},
    '{1'b1,1'b0,W_ACC,  5'd1, 32'h0,        32'h00070000, 8'd6},  // R6
    '{1'b0,1'b1,W_TRIG, 5'd1, 32'hFFFFFFFF, 32'h0,        8'd13},
    '{1'b1,1'b0,W_TRIG, 5'd1, 32'h0,        32'h0000FFFF, 8'd13}, // R13
    '{1'b0,1'b1,W_GRANT,5'd3, 32'hFFFFFFFF, 32'h0,        8'd10},
    '{1'b1,1'b0,W_GRANT,5'd3, 32'h0,        32'h00000039, 8'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0, secure = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [NUM_IRQ-33:0] lines = '0;
  logic        rvalid;
  logic [31:0] rdata;
  int          checks = 0;
  int          errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  irq_bitmap_bank #(.NUM_IRQ(NUM_IRQ)) u_irq_bitmap_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(valid), .req_write_i(write), .req_secure_i(secure),
    .req_addr_i(addr), .req_wdata_i(wdata),
    .irq_lines_i(lines),
    .rsp_valid_o(rvalid), .rsp_rdata_o(rdata)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input logic s, input logic w, input logic [3:0] wn,
                        input logic [4:0] ix, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    valid = 1'b1; write = w; secure = s; addr = {wn, ix}; wdata = d;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    r = rdata;
    if (!w) check({31'h0, rvalid}, 32'h1, "R12 read response valid");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].sec, VEC[i].wr, VEC[i].win, VEC[i].idx, VEC[i].wd, rd);
      if (!VEC[i].wr) check(rd, VEC[i].exp, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end

    // R8 / R7: word 2, bits 0..3 edge-triggered, bit 4 level-triggered
    access(1'b1, 1'b1, W_TRIG, 5'd2, 32'h0000000F, rd);
    @(negedge clk); lines[32] = 1'b1; lines[36] = 1'b1;
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h00000011, "R7 R8 latched edge plus live level");
    @(negedge clk); lines[32] = 1'b0; lines[36] = 1'b0;
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h00000001, "R7 level gone, R8 edge stays latched");
    @(negedge clk); lines[33] = 1'b1;
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h00000003, "R8 second edge latched");
    access(1'b1, 1'b1, W_PDC, 5'd2, 32'h00000002, rd);
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h00000001, "R8 steady high does not relatch");

    // R9: rising edge and clear-pending in the same cycle
    @(negedge clk);
    lines[34] = 1'b1;
    valid = 1'b1; write = 1'b1; secure = 1'b1; addr = {W_PDC, 5'd2}; wdata = 32'h00000004;
    @(negedge clk);
    valid = 1'b0; write = 1'b0;
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h00000005, "R9 edge beats clear");

    // R11 control bit
    access(1'b0, 1'b1, W_CTRL, 5'd0, 32'h1, rd);
    access(1'b1, 1'b0, W_CTRL, 5'd0, 32'h0, rd);
    check(rd, 32'h0, "R11 non-secure cannot set security-off");
    access(1'b1, 1'b1, W_CTRL, 5'd0, 32'h1, rd);
    access(1'b0, 1'b0, W_CTRL, 5'd0, 32'h0, rd);
    check(rd, 32'h1, "R11 secure sets security-off");
    access(1'b1, 1'b1, W_CTRL, 5'd0, 32'h0, rd);
    access(1'b1, 1'b0, W_CTRL, 5'd0, 32'h0, rd);
    check(rd, 32'h1, "R11 security-off is sticky");

    // R3 all lanes open with security off
    access(1'b0, 1'b0, W_GRP, 5'd1, 32'h0, rd);
    check(rd, 32'h0000FFFF, "R3 non-secure group read open");
    access(1'b0, 1'b1, W_ENS, 5'd1, 32'hFFFFFFFF, rd);
    access(1'b0, 1'b0, W_ENS, 5'd1, 32'h0, rd);
    check(rd, 32'hFFFFFFFF, "R3 non-secure enable write open");
    access(1'b1, 1'b0, W_GRANT, 5'd3, 32'h0, rd);
    check(rd, 32'h0, "R10 grant reads zero once security off");

    // R12 reset state
    @(negedge clk); lines = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check({31'h0, rvalid}, 32'h0, "R12 rsp_valid low in reset");
    rst_n = 1'b1;
    access(1'b1, 1'b0, W_CTRL, 5'd0, 32'h0, rd);
    check(rd, 32'h0, "R12 security-off clear after reset");
    access(1'b1, 1'b0, W_ENS, 5'd1, 32'h0, rd);
    check(rd, 32'h0, "R12 enable clear after reset");
    access(1'b1, 1'b0, W_PDS, 5'd2, 32'h0, rd);
    check(rd, 32'h0, "R12 pending clear after reset");

    finish_run();
  end
endmodule